// File: doc/BRIEF.md
# Add/Subtract Unit with Status Flags

This block is a 32-bit adder/subtractor with a flags register. It takes two operands and a two-bit operation select, and produces a 32-bit result. It also produces six status bits that describe that result: carry, overflow, sign, zero, auxiliary carry and parity.

The two chained operations, add-with-carry and subtract-with-borrow, take their carry-in from the carry bit already stored in the flags register. This lets a sequence of operations carry or borrow across words wider than 32 bits.

The same register also holds three control bits: direction, interrupt-enable and trace. Each of these is set or cleared by a small command input. Arithmetic never alters them.

The result is combinational from the inputs and the stored carry. The flags register updates on the rising clock edge.

Top module: `addsub_flags`

## Requirements
- R1: With op_sel 00 (add), result equals op_a + op_b modulo 2^32. With op_sel 01 (add-with-carry), result equals op_a + op_b + stored carry modulo 2^32.
- R2: With op_sel 10 (subtract), result equals op_a - op_b modulo 2^32. With op_sel 11 (subtract-with-borrow), result equals op_a - op_b - stored carry modulo 2^32.
- R3: On a flag write, flags[0] (carry) takes the unsigned carry out for additions. For subtractions it takes the borrow, which is 1 when the true difference is negative.
- R4: On a flag write, flags[5] (overflow) is 1 when the signed value of the operation lies outside -2^31 to 2^31-1.
- R5: On a flag write, flags[4] (sign) takes bit 31 of the result.
- R6: On a flag write, flags[3] (zero) is 1 exactly when the result is all zeros.
- R7: On a flag write, flags[2] (auxiliary) is 1 when the low four bits produce a carry out of bit 3 (add) or need a borrow into bit 3 (subtract). Any carry-in or borrow-in is included.
- R8: On a flag write, flags[1] (parity) is 1 when result[7:0] holds an even number of 1 bits.
- R9: While flag_we is 0, flags[5:0] keep their values.
- R10: ctl_cmd codes act on the control bits as follows:
  - 1 sets flags[6] (direction) and 2 clears it.
  - 3 sets flags[7] (interrupt-enable) and 4 clears it.
  - 5 sets flags[8] (trace) and 6 clears it.
  - 0 and 7 do nothing.
  - Arithmetic and flag_we never change flags[8:6].
- R11: While rst_n is 0, all nine flag bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 2 | 00 add, 01 add-with-carry, 10 subtract, 11 subtract-with-borrow |
| flag_we | input | 1 | Latch the six status bits at the clock edge |
| ctl_cmd | input | 3 | Set or clear command for the control bits |
| result | output | 32 | Arithmetic result |
| flags | output | 9 | {trace, int-enable, direction, overflow, sign, zero, aux, parity, carry} |

## Verification
The chained operations are the hard case, because their carry-in is internal state. It can only be set by an earlier operation that wrote the flags. Subtract-with-borrow with a stored borrow of 1 against equal operands is a further case: the true difference is -1, so the step wraps to all ones and raises the borrow again.

The stimulus reaches these states in two ways. Directed pairs first force a carry or borrow and then issue the chained operation. Long random runs then mix every operation select with random flag writes and control commands. A behavioural model in the bench, built on wide signed and unsigned integers, is compared with the result and all nine flags on every cycle.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   op_sel,
  input  logic         flag_we,
  input  logic [2:0]   ctl_cmd,
  output logic [W-1:0] result,
  output logic [8:0]   flags
);

  logic       is_sub, cin;
  logic [W-1:0] b_eff;
  logic [W:0] sum;
  logic [4:0] nib;
  logic       msb_cin, c_flag, v_flag, a_flag, p_flag, z_flag, s_flag;

  assign is_sub  = op_sel[1];
  assign b_eff   = is_sub ? ~op_b : op_b;
  assign cin     = is_sub ^ (op_sel[0] & flags[0]);
  assign sum     = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign nib     = {1'b0, op_a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0, cin};
  assign msb_cin = op_a[W-1] ^ b_eff[W-1] ^ sum[W-1];

  assign result  = sum[W-1:0];
  assign c_flag  = sum[W] ^ is_sub;
  assign v_flag  = msb_cin ^ sum[W];
  assign a_flag  = nib[4] ^ is_sub;
  assign p_flag  = ~^sum[7:0];
  assign z_flag  = (sum[W-1:0] == '0);
  assign s_flag  = sum[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      if (flag_we)
        flags[5:0] <= {v_flag, s_flag, z_flag, a_flag, p_flag, c_flag};
      case (ctl_cmd)
        3'd1: flags[6] <= 1'b1;
        3'd2: flags[6] <= 1'b0;
        3'd3: flags[7] <= 1'b1;
        3'd4: flags[7] <= 1'b0;
        3'd5: flags[8] <= 1'b1;
        3'd6: flags[8] <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

module addsub_flags_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flag_we,
  input logic [2:0]   ctl_cmd,
  input logic [W-1:0] result,
  input logic [8:0]   flags
);

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> flags[5:0] == $past(flags[5:0]));

  // R10
  ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_cmd == 3'd0 || ctl_cmd == 3'd7) |=> flags[8:6] == $past(flags[8:6]));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags[3] == ($past(result) == '0));

  // R5
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags[4] == $past(result[W-1]));

  // R8
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags[1] == ~^$past(result[7:0]));

  // R11
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> flags == 9'd0));

endmodule

bind addsub_flags addsub_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .ctl_cmd(ctl_cmd),
  .result(result), .flags(flags)
);

// File: tb/test_addsub_flags.sv
`timescale 1ns/1ps
module test_addsub_flags;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic [1:0]  op_sel = 0;
  logic        flag_we = 0;
  logic [2:0]  ctl_cmd = 0;
  logic [31:0] result;
  logic [8:0]  flags;

  int total = 0, bad = 0;
  logic [8:0] mflags = 0;
  bit done = 0;

  always #2 clk = ~clk;

  addsub_flags i_addsub_flags (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flag_we(flag_we), .ctl_cmd(ctl_cmd), .result(result), .flags(flags)
  );

  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                       input logic cf, output logic [31:0] r, output logic [5:0] st);
    longint ci, ua, ub, full, sa, sb, sfull, lo;
    int ones;
    ci = (op[0] && cf) ? 1 : 0;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    if (!op[1]) begin
      full = ua + ub + ci; sfull = sa + sb + ci; lo = (ua % 16) + (ub % 16) + ci;
      st[0] = full > 64'sd4294967295;
      st[2] = lo > 15;
    end else begin
      full = ua - ub - ci; sfull = sa - sb - ci; lo = (ua % 16) - (ub % 16) - ci;
      st[0] = full < 0;
      st[2] = lo < 0;
    end
    r = full[31:0];
    st[5] = (sfull > 64'sd2147483647) || (sfull < -64'sd2147483648);
    st[4] = r[31];
    st[3] = (r == 0);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += r[i];
    st[1] = (ones % 2) == 0;
  endtask

  always @(posedge clk) begin
    logic [31:0] r;
    logic [5:0] st;
    if (!rst_n) mflags <= 0;
    else begin
      logic [8:0] n;
      n = mflags;
      model(op_a, op_b, op_sel, mflags[0], r, st);
      if (flag_we) n[5:0] = st;
      case (ctl_cmd)
        3'd1: n[6] = 1; 3'd2: n[6] = 0;
        3'd3: n[7] = 1; 3'd4: n[7] = 0;
        3'd5: n[8] = 1; 3'd6: n[8] = 0;
        default: ;
      endcase
      mflags <= n;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [31:0] r;
    logic [5:0] st;
    model(op_a, op_b, op_sel, mflags[0], r, st);
    chk(op_sel[1] ? "R2 result" : "R1 result", result, r);
    chk("R3 carry", 32'(flags[0]), 32'(mflags[0]));
    chk("R8 parity", 32'(flags[1]), 32'(mflags[1]));
    chk("R7 aux", 32'(flags[2]), 32'(mflags[2]));
    chk("R6 zero", 32'(flags[3]), 32'(mflags[3]));
    chk("R5 sign", 32'(flags[4]), 32'(mflags[4]));
    chk("R4 overflow", 32'(flags[5]), 32'(mflags[5]));
    chk("R9 R10 flags", 32'(flags), 32'(mflags));
  end

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                       input logic we, input logic [2:0] cmd);
    @(posedge clk); #1;
    op_a = a; op_b = b; op_sel = op; flag_we = we; ctl_cmd = cmd;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R11 reset flags", 32'(flags), 0);
    rst_n = 1;
    drive(32'hFFFF_FFFF, 32'h1, 2'b00, 1, 0);
    drive(32'h0, 32'h0, 2'b01, 1, 0);
    drive(32'h5, 32'h5, 2'b11, 1, 1);
    drive(32'h5, 32'h5, 2'b11, 1, 3);
    drive(32'h7FFF_FFFF, 32'h1, 2'b00, 1, 5);
    drive(32'h8000_0000, 32'h1, 2'b10, 1, 0);
    drive(32'h0000_000F, 32'h1, 2'b00, 1, 2);
    drive(32'h1234_5678, 32'h9ABC_DEF0, 2'b00, 0, 4);
    drive(32'h0000_0010, 32'h1, 2'b10, 1, 6);
    drive(32'h0, 32'h1, 2'b10, 0, 7);
    for (int i = 0; i < 20000; i++)
      drive($urandom, (i % 5 == 0) ? 32'h0 : $urandom, 2'($urandom),
            1'($urandom), 3'($urandom));
    drive(0, 0, 0, 0, 0);
    @(posedge clk); #1;
    rst_n = 0;
    @(posedge clk); #1;
    chk("R11 reset flags", 32'(flags), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule